// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

This block turns the raw decisions of a ten-stage pipelined analog-to-digital converter into one corrected 12-bit result per sample. The front stage delivers a 4-bit decision, eight middle stages each deliver a three-level decision on two wires, and the final stage delivers one bit. Each stage sees a given sample half a conversion period after the stage before it. The codes of one sample therefore reach the block spread over nine ticks of a clock that runs at twice the conversion rate.

Each stage's code passes through its own delay line, so that all ten codes of a sample meet on the same tick. The aligned codes are then summed with overlapping binary weights. The front code carries weight 256. Middle stage k carries weight 2^(9-k), and the last bit carries weight 1. Because neighbouring weights overlap, a comparator offset in any stage except the last moves value between neighbouring terms without opening a gap in the output codes. Sums above the 12-bit range are clamped, and a range flag marks them. A valid strobe tells downstream logic when the alignment lines hold real data.

Top module: `pdec_correct`

## Requirements
- R1: The front code `front_code` (0..15) contributes front_code × 256 to the sum.
- R2: Middle stage k (k = 2..9) is carried on `mid_code[2*(k-2)+1 : 2*(k-2)]`, where 00 means 0, 01 means 1 and 10 means 2, and it contributes that value × 2^(9-k).
- R3: A middle code of 11 is treated exactly as 01.
- R4: `tail_bit` (stage 10) contributes its value × 1.
- R5: Stage k's code for sample n is expected on the tick numbered 2n + (k-1), counted from the first clock edge after reset is released, and held for two ticks. The word for sample n appears after edge 2n + 9 and stays for two ticks.
- R6: When the weighted sum exceeds 4095, `word_o` is 4095 and `range_o` is 1. Otherwise `word_o` equals the sum and `range_o` is 0.
- R7: `range_o` belongs to the word currently on `word_o`, and it is never high while `valid_o` is low.
- R8: After reset is released, `valid_o` stays low for the first nine edges and goes high after the tenth edge (edge index 9). It then stays high while reset stays released, so each word is valid for its whole conversion period.
- R9: A synchronous active-low reset clears all alignment registers and drives `word_o` to 0, `range_o` to 0 and `valid_o` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the conversion rate (one tick per half conversion period) |
| rst_n | input | 1 | Synchronous active-low reset |
| front_code | input | 4 | Stage 1 decision, 0..15 |
| mid_code | input | 16 | Stages 2..9, two bits each, stage 2 in the lowest pair |
| tail_bit | input | 1 | Stage 10 decision |
| word_o | output | 12 | Corrected, clamped output word |
| range_o | output | 1 | High when the word was clamped |
| valid_o | output | 1 | High once the alignment lines are filled |

## Verification
Directed samples light a single stage at a time: only the front code, only one middle stage at code 10, or only the tail bit. A wrong weight or a wrong skew for that stage then shows up as a word that is plainly wrong. Samples with every middle code at 11 separate illegal-code folding from ordinary decoding. The pair of samples summing to 4095 and to 4096 pins the clamp boundary, and the all-maximum sample checks the flag. Random samples whose codes change every conversion period expose any stage delayed by the wrong number of ticks, because that stage's term is then taken from the neighbouring sample. A mid-stream reset checks the clearing and the refill timing.

// File: rtl/pdec_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the middle-stage code cleanup used by the
// stage-code combiner. Assumes middle stages use two wires with three legal
// levels.
package pdec_pkg;

    localparam int STAGES_DEF     = 10;
    localparam int FRONT_BITS_DEF = 4;
    localparam int OUT_BITS_DEF   = 12;

    // Fold the unused two-wire pattern onto the middle level.
    function automatic logic [1:0] fold_mid(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'b01 : raw;
    endfunction

endpackage

// File: rtl/pdec_skew.sv
`timescale 1ns/1ps
// Module: pdec_skew
// Delays one stage's code by DEPTH clock ticks so that it lines up with the
// codes of later stages of the same sample. DEPTH of zero is a plain wire.
// Assumes a synchronous active-low reset that clears every tap.
module pdec_skew #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_line
            logic [W-1:0] tap_q [DEPTH];

            // Shift the code one tap per tick; reset empties the line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int t = 0; t < DEPTH; t++) tap_q[t] <= '0;
                end else begin
                    tap_q[0] <= d_i;
                    for (int t = 1; t < DEPTH; t++) tap_q[t] <= tap_q[t-1];
                end
            end

            assign q_o = tap_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pdec_sum.sv
`timescale 1ns/1ps
// Module: pdec_sum
// Combinational weighted sum of aligned stage codes with overlapping binary
// weights, followed by a clamp to the output range. The front code is worth
// 2^N_MID, middle stage i (0 based) is worth 2^(N_MID-1-i), and the tail
// bit is worth 1. Assumes middle codes are already folded to 0..2.
module pdec_sum #(
    parameter int FRONT_BITS = 4,
    parameter int N_MID      = 8,
    parameter int OUT_BITS   = 12
) (
    input  logic [FRONT_BITS-1:0] front_i,
    input  logic [2*N_MID-1:0]    mid_i,
    input  logic                  tail_i,
    output logic [OUT_BITS-1:0]   word_o,
    output logic                  over_o
);

    localparam int SUM_W = FRONT_BITS + N_MID + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'({OUT_BITS{1'b1}});

    logic [SUM_W-1:0] acc;

    // Accumulate each aligned term at its weight.
    always_comb begin
        acc = SUM_W'(front_i) << N_MID;
        for (int i = 0; i < N_MID; i++) begin
            acc = acc + (SUM_W'(mid_i[2*i +: 2]) << (N_MID - 1 - i));
        end
        acc = acc + SUM_W'(tail_i);
    end

    // Saturate anything beyond the output range and flag it.
    always_comb begin
        over_o = (acc > TOP);
        word_o = over_o ? {OUT_BITS{1'b1}} : acc[OUT_BITS-1:0];
    end

endmodule

// File: rtl/pdec_fill.sv
`timescale 1ns/1ps
// Module: pdec_fill
// Tracks how many ticks have passed since reset and raises the valid strobe
// once every alignment line holds data of a real sample. Assumes the
// alignment plus output stage spans FILL ticks.
module pdec_fill #(
    parameter int FILL = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid_o
);

    localparam int CW = $clog2(FILL + 1);
    localparam logic [CW-1:0] LAST = CW'(FILL);
    localparam logic [CW-1:0] ARM  = CW'(FILL - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks since reset, saturating once the lines are full.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Valid follows the count one tick later, aligned to the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else valid_o <= (cnt_q >= ARM);
    end

    // R8: once valid, it stays valid until reset.
    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

endmodule

// File: rtl/pdec_correct.sv
`timescale 1ns/1ps
// Module: pdec_correct
// Digital correction for a pipelined converter: aligns staggered per-stage
// codes with per-stage delay lines, sums them with overlapping weights,
// clamps, and registers word, range flag and valid strobe together.
// Assumes clk runs at twice the conversion rate and each stage code is held
// for two ticks, stage k starting k-1 ticks after stage 1.
module pdec_correct
    import pdec_pkg::*;
#(
    parameter int N_STAGE    = STAGES_DEF,
    parameter int FRONT_BITS = FRONT_BITS_DEF,
    parameter int OUT_BITS   = OUT_BITS_DEF,
    parameter int N_MID      = N_STAGE - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRONT_BITS-1:0] front_code,
    input  logic [2*N_MID-1:0]    mid_code,
    input  logic                  tail_bit,
    output logic [OUT_BITS-1:0]   word_o,
    output logic                  range_o,
    output logic                  valid_o
);

    localparam int FRONT_LAG = N_STAGE - 1;

    logic [FRONT_BITS-1:0] front_al;
    logic [2*N_MID-1:0]    mid_al;
    logic                  tail_al;
    logic [OUT_BITS-1:0]   word_d;
    logic                  over_d;

    // Stage 1 arrives first and waits longest.
    pdec_skew #(.W(FRONT_BITS), .DEPTH(FRONT_LAG)) u_front_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (front_code),
        .q_o  (front_al)
    );

    // Middle stages: fold the illegal pattern, then delay by N_STAGE-k.
    generate
        for (genvar i = 0; i < N_MID; i++) begin : g_mid
            logic [1:0] clean;
            assign clean = fold_mid(mid_code[2*i +: 2]);

            pdec_skew #(.W(2), .DEPTH(N_STAGE - 2 - i)) u_mid_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .d_i  (clean),
                .q_o  (mid_al[2*i +: 2])
            );

            // R3: no illegal pattern ever reaches the adder.
            p_no_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
                mid_al[2*i +: 2] != 2'b11);
        end
    endgenerate

    // The last stage arrives last and needs no delay.
    pdec_skew #(.W(1), .DEPTH(0)) u_tail_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (tail_bit),
        .q_o  (tail_al)
    );

    pdec_sum #(.FRONT_BITS(FRONT_BITS), .N_MID(N_MID), .OUT_BITS(OUT_BITS)) u_sum (
        .front_i(front_al),
        .mid_i  (mid_al),
        .tail_i (tail_al),
        .word_o (word_d),
        .over_o (over_d)
    );

    pdec_fill #(.FILL(N_STAGE)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_o(valid_o)
    );

    // Register the corrected word and its range flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            range_o <= 1'b0;
        end else begin
            word_o  <= word_d;
            range_o <= over_d;
        end
    end

    // R6: a flagged word always sits at full scale.
    p_clamp_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        range_o |-> (word_o == {OUT_BITS{1'b1}}));

    // R7: the range flag never rises before the lines are filled.
    p_flag_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        range_o |-> valid_o);

    // R9: a reset edge leaves every output cleared.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !range_o && word_o == '0));

endmodule

// File: tb/pdec_correct_tb.sv
`timescale 1ns/1ps
module pdec_correct_tb;

    localparam int NS     = 160;
    localparam int NMID   = 8;
    localparam int FILLED = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  front_code = '0;
    logic [15:0] mid_code = '0;
    logic        tail_bit = 1'b0;
    logic [11:0] word_o;
    logic        range_o;
    logic        valid_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [3:0]  s_f [NS];
    logic [15:0] s_m [NS];
    logic        s_t [NS];
    string       s_tag [NS];

    always #4 clk = ~clk;

    pdec_correct u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .front_code(front_code),
        .mid_code  (mid_code),
        .tail_bit  (tail_bit),
        .word_o    (word_o),
        .range_o   (range_o),
        .valid_o   (valid_o)
    );

    function automatic int ref_sum(logic [3:0] f, logic [15:0] m, logic t);
        int s = int'(f) * 256;
        for (int j = 0; j < NMID; j++) begin
            logic [1:0] c = m[2*j +: 2];
            int v = (c == 2'b11) ? 1 : int'(c);
            s += v * (1 << (7 - j));
        end
        return s + int'(t);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive the codes that each stage shows on edge e.
    task automatic drive(int e, int nsamp);
        int n;
        n = e >> 1;
        front_code = (n < nsamp) ? s_f[n] : 4'd0;
        for (int j = 0; j < NMID; j++) begin
            int r = e - (j + 1);
            int idx = r >> 1;
            mid_code[2*j +: 2] = (r >= 0 && idx < nsamp) ? s_m[idx][2*j +: 2] : 2'b00;
        end
        begin
            int r = e - 9;
            int idx = r >> 1;
            tail_bit = (r >= 0 && idx < nsamp) ? s_t[idx] : 1'b0;
        end
    endtask

    // Run a stream after reset release; verify valid, word and flag per tick.
    task automatic run_stream(int nsamp);
        for (int e = 0; e < 2 * nsamp + FILLED; e++) begin
            drive(e, nsamp);
            @(posedge clk);
            @(negedge clk);
            check("R8 valid", int'(valid_o), (e >= FILLED) ? 1 : 0);
            if (e >= FILLED) begin
                int n = (e - FILLED) >> 1;
                int s = ref_sum(s_f[n], s_m[n], s_t[n]);
                int ew = (s > 4095) ? 4095 : s;
                check({s_tag[n], " word"}, int'(word_o), ew);
                check("R7 range flag", int'(range_o), (s > 4095) ? 1 : 0);
            end
        end
    endtask

    task automatic apply_reset(int edges);
        rst_n = 1'b0;
        for (int i = 0; i < edges; i++) begin
            front_code = 4'($urandom);
            mid_code = 16'($urandom);
            tail_bit = 1'($urandom);
            @(posedge clk);
            @(negedge clk);
            check("R9 word cleared", int'(word_o), 0);
            check("R9 range cleared", int'(range_o), 0);
            check("R9 valid cleared", int'(valid_o), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic set_s(int i, logic [3:0] f, logic [15:0] m, logic t, string tag);
        s_f[i] = f; s_m[i] = m; s_t[i] = t; s_tag[i] = tag;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < NS; i++) begin
            set_s(i, 4'($urandom), 16'($urandom), 1'($urandom), "R5 random");
        end
        set_s(0, 4'd0,  16'h0000, 1'b0, "R1 zero");
        set_s(1, 4'd9,  16'h0000, 1'b0, "R1 front only");
        set_s(2, 4'd0,  16'h0002, 1'b0, "R2 stage2 level2");
        set_s(3, 4'd0,  16'h4000, 1'b0, "R2 stage9 level1");
        set_s(4, 4'd0,  16'h0080, 1'b0, "R2 stage5 level2");
        set_s(5, 4'd0,  16'h0000, 1'b1, "R4 tail only");
        set_s(6, 4'd3,  16'hFFFF, 1'b0, "R3 all illegal");
        set_s(7, 4'd15, 16'h5555, 1'b0, "R6 exactly 4095");
        set_s(8, 4'd15, 16'h5555, 1'b1, "R6 4096 clamp");
        set_s(9, 4'd15, 16'hAAAA, 1'b1, "R6 max clamp");
        set_s(10, 4'd0, 16'h0C00, 1'b1, "R3 stage7 illegal");
        set_s(11, 4'd15, 16'hFFFF, 1'b1, "R3 illegal near top");

        apply_reset(3);
        run_stream(NS);
        apply_reset(2);
        run_stream(20);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule